// File: doc/BRIEF.md
# Stream Crossbar Switch with Held Arbitration

The block is a stream crossbar. It links NS source ports to NM sink ports, and the port counts range from 1 to 16. Each beat carries a destination field, and each sink port owns an inclusive window of destination values. A beat goes to the sink whose window contains its destination. A beat whose destination falls inside no window is accepted and dropped, so the source never stalls on it.

Each sink port has its own arbiter, so several sinks can serve different sources in the same cycle. When sources compete for one sink, the arbiter grants one of them. It uses either round-robin or fixed priority, chosen by a parameter. The grant then stays with that source until a release condition fires. Three release conditions can each be enabled by parameter:
- a limit on the number of accepted beats;
- a run of idle cycles;
- an accepted beat that closes a packet.

An optional clock enable freezes the whole block. With a single source the arbiter is bypassed and only the destination decode applies.

Top module: `strm_xbar`

## Requirements
- R1: A beat is presented only on the sink whose inclusive window [DST_LO, DST_HI] contains its destination. Where windows overlap, the lowest-index sink wins. The default windows are sink 0 = 0..2 and sink 1 = 2..5.
- R2: A valid beat whose destination lies in no window is accepted (ready high while enabled) and appears on no sink. With the default windows these destinations are 6 and 7.
- R3: While a source holds a sink, that sink's valid, data, last and destination come only from that source. That source's ready follows the sink's ready. Every other source sees ready low for that sink.
- R4: With ARB_RR = 0, a free sink grants the lowest-index requesting source.
- R5: With ARB_RR = 1, a free sink searches starting from the source after the one it last granted. After reset the search starts at source 0.
- R6: A grant stays with its source across beats. Other requesters wait until a release condition fires.
- R7: With MAX_XFER > 0, the grant is released on the MAX_XFER-th accepted beat. The default is 3.
- R8: With IDLE_LIM > 0, the grant is released after IDLE_LIM consecutive cycles in which the holder presents no valid beat for that sink, even if no beat was accepted. The default is 2.
- R9: With REL_ON_LAST = 1, the grant is released on an accepted beat with last high.
- R10: Different sinks may serve different sources in the same cycle. A source that holds one sink cannot be granted another sink until its grant is released.
- R11: With USE_CE = 1 and ce_i low, every sink valid and every source ready is low. No grant, counter or pointer changes.
- R12: Reset clears all grants, counters and round-robin pointers. With no valid input, every output valid and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for all ports (used when USE_CE = 1) |
| s_valid_i | input | NS | Source beat valid |
| s_ready_o | output | NS | Source beat accepted |
| s_data_i | input | NS*DATA_W | Source data, source j at bits j*DATA_W |
| s_last_i | input | NS | Source end-of-packet flag |
| s_dest_i | input | NS*DEST_W | Source destination field |
| m_valid_o | output | NM | Sink beat valid |
| m_ready_i | input | NM | Sink ready |
| m_data_o | output | NM*DATA_W | Sink data |
| m_last_o | output | NM | Sink end-of-packet flag |
| m_dest_o | output | NM*DEST_W | Sink destination field |

## Verification
The grant drives the sink multiplexer combinationally. A wrong held owner therefore shows in the same cycle: the sink carries another source's data, or a waiting source sees ready. A beat counter or idle counter that is off by one moves the point where the grant passes to the next source by one cycle, and the sink's data shows it at that point. A stale round-robin pointer shows on the next free-sink decision as a repeated or skipped source. A freeze that leaks past the clock enable shows as a grant that changes earlier than the count of enabled cycles allows.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int unsigned NM = 2,
  parameter int unsigned DEST_W = 3,
  parameter logic [NM*DEST_W-1:0] LO = '0,
  parameter logic [NM*DEST_W-1:0] HI = '0
) (
  input  logic [DEST_W-1:0] dest_i,
  output logic [NM-1:0]     sel_o,
  output logic              miss_o
);
  logic found;

  // lowest-index window wins on overlap
  always_comb begin
    sel_o = '0;
    found = 1'b0;
    for (int k = 0; k < NM; k++) begin
      if (!found && dest_i >= LO[k*DEST_W +: DEST_W] && dest_i <= HI[k*DEST_W +: DEST_W]) begin
        sel_o[k] = 1'b1;
        found    = 1'b1;
      end
    end
    miss_o = !found;
  end
endmodule

// File: rtl/xbar_arb.sv
module xbar_arb #(
  parameter int unsigned NS = 3,
  parameter int unsigned MAX_XFER = 3,
  parameter int unsigned IDLE_LIM = 2,
  parameter bit REL_ON_LAST = 1'b1,
  parameter bit ARB_RR = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic [NS-1:0] req_i,
  input  logic [NS-1:0] vld_i,
  input  logic [NS-1:0] last_i,
  input  logic          ready_i,
  output logic [NS-1:0] gnt_o,
  output logic [NS-1:0] held_o
);
  localparam int unsigned IDX_W = xbar_pkg::idx_w(NS);
  localparam int unsigned CNT_W = xbar_pkg::idx_w(MAX_XFER + 1);
  localparam int unsigned IDL_W = xbar_pkg::idx_w(IDLE_LIM + 1);

  if (NS == 1) begin : g_bypass
    assign gnt_o  = vld_i;
    assign held_o = '0;
  end else begin : g_arb
    logic             held_q, v, lst, xfer, active, rel;
    logic [NS-1:0]    own_q, pick_oh, cur;
    logic [IDX_W-1:0] ptr_q, pick_idx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [IDL_W-1:0] idle_q, idle_nx;

    if (ARB_RR) begin : g_rr
      always_comb begin
        pick_oh  = '0;
        pick_idx = ptr_q;
        for (int off = 1; off <= NS; off++) begin
          int i;
          i = (int'(ptr_q) + off) % NS;
          if (pick_oh == '0 && req_i[i]) begin
            pick_oh[i] = 1'b1;
            pick_idx   = IDX_W'(i);
          end
        end
      end
    end else begin : g_fp
      always_comb begin
        pick_oh  = '0;
        pick_idx = ptr_q;
        for (int i = 0; i < NS; i++) begin
          if (pick_oh == '0 && req_i[i]) begin
            pick_oh[i] = 1'b1;
            pick_idx   = IDX_W'(i);
          end
        end
      end
    end

    assign cur     = held_q ? own_q : pick_oh;
    assign v       = |(cur & vld_i);
    assign lst     = |(cur & last_i);
    assign xfer    = v & ready_i;
    assign active  = held_q | (|pick_oh);
    assign cnt_nx  = (held_q ? cnt_q : '0) + CNT_W'(xfer);
    assign idle_nx = v ? '0 : (held_q ? idle_q : '0) + IDL_W'(1);

    always_comb begin
      rel = 1'b0;
      if (MAX_XFER != 0 && xfer && cnt_nx == CNT_W'(MAX_XFER)) rel = 1'b1;
      if (REL_ON_LAST && xfer && lst) rel = 1'b1;
      if (IDLE_LIM != 0 && !v && idle_nx == IDL_W'(IDLE_LIM)) rel = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        held_q <= 1'b0;
        own_q  <= '0;
        ptr_q  <= IDX_W'(NS - 1);
        cnt_q  <= '0;
        idle_q <= '0;
      end else if (ce_i) begin
        held_q <= active & ~rel;
        if (!held_q && active) begin
          own_q <= pick_oh;
          ptr_q <= pick_idx;
        end
        cnt_q  <= active ? cnt_nx : '0;
        idle_q <= active ? idle_nx : '0;
      end
    end

    assign gnt_o  = cur;
    assign held_o = held_q ? own_q : '0;
  end
endmodule

// File: rtl/strm_xbar.sv
module strm_xbar #(
  parameter int unsigned NS = 3,
  parameter int unsigned NM = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEST_W = 3,
  parameter logic [NM*DEST_W-1:0] DST_LO = {3'd2, 3'd0},
  parameter logic [NM*DEST_W-1:0] DST_HI = {3'd5, 3'd2},
  parameter int unsigned MAX_XFER = 3,
  parameter int unsigned IDLE_LIM = 2,
  parameter bit REL_ON_LAST = 1'b1,
  parameter bit ARB_RR = 1'b1,
  parameter bit USE_CE = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic [NS-1:0]        s_valid_i,
  output logic [NS-1:0]        s_ready_o,
  input  logic [NS*DATA_W-1:0] s_data_i,
  input  logic [NS-1:0]        s_last_i,
  input  logic [NS*DEST_W-1:0] s_dest_i,
  output logic [NM-1:0]        m_valid_o,
  input  logic [NM-1:0]        m_ready_i,
  output logic [NM*DATA_W-1:0] m_data_o,
  output logic [NM-1:0]        m_last_o,
  output logic [NM*DEST_W-1:0] m_dest_o
);
  logic                   ce;
  logic [NS-1:0][NM-1:0]  sel;
  logic [NS-1:0]          miss, held_any;
  logic [NM-1:0][NS-1:0]  vld, req, gnt, held;

  assign ce = USE_CE ? ce_i : 1'b1;

  for (genvar j = 0; j < NS; j++) begin : g_src
    xbar_route #(.NM(NM), .DEST_W(DEST_W), .LO(DST_LO), .HI(DST_HI)) u_route (
      .dest_i(s_dest_i[j*DEST_W +: DEST_W]),
      .sel_o (sel[j]),
      .miss_o(miss[j])
    );
  end

  // a source holding one sink is masked from all others
  always_comb begin
    held_any = '0;
    for (int k = 0; k < NM; k++) held_any = held_any | held[k];
    for (int k = 0; k < NM; k++) begin
      for (int j = 0; j < NS; j++) begin
        vld[k][j] = s_valid_i[j] & sel[j][k];
        req[k][j] = vld[k][j] & ~(held_any[j] & ~held[k][j]);
      end
    end
  end

  for (genvar k = 0; k < NM; k++) begin : g_snk
    xbar_arb #(
      .NS(NS), .MAX_XFER(MAX_XFER), .IDLE_LIM(IDLE_LIM),
      .REL_ON_LAST(REL_ON_LAST), .ARB_RR(ARB_RR)
    ) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_i   (ce),
      .req_i  (req[k]),
      .vld_i  (vld[k]),
      .last_i (s_last_i),
      .ready_i(m_ready_i[k]),
      .gnt_o  (gnt[k]),
      .held_o (held[k])
    );
  end

  always_comb begin
    m_valid_o = '0;
    m_data_o  = '0;
    m_last_o  = '0;
    m_dest_o  = '0;
    s_ready_o = '0;
    for (int k = 0; k < NM; k++) begin
      for (int j = 0; j < NS; j++) begin
        if (gnt[k][j]) begin
          m_valid_o[k] = m_valid_o[k] | (ce & vld[k][j]);
          m_data_o[k*DATA_W +: DATA_W] = m_data_o[k*DATA_W +: DATA_W] | s_data_i[j*DATA_W +: DATA_W];
          m_last_o[k] = m_last_o[k] | s_last_i[j];
          m_dest_o[k*DEST_W +: DEST_W] = m_dest_o[k*DEST_W +: DEST_W] | s_dest_i[j*DEST_W +: DEST_W];
          s_ready_o[j] = s_ready_o[j] | (ce & sel[j][k] & m_ready_i[k]);
        end
      end
    end
    for (int j = 0; j < NS; j++) s_ready_o[j] = s_ready_o[j] | (ce & miss[j]);
  end
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int unsigned NS = 3,
  parameter int unsigned NM = 2,
  parameter bit REL_ON_LAST = 1'b1,
  parameter bit USE_CE = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ce_i,
  input logic [NS-1:0]   s_ready_o,
  input logic [NS-1:0]   miss_i,
  input logic [NM-1:0]   m_valid_o,
  input logic [NM-1:0]   m_ready_i,
  input logic [NM-1:0]   m_last_o,
  input logic [NM*NS-1:0] held_i
);
  p_ce_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (USE_CE && !ce_i) |-> (m_valid_o == '0 && s_ready_o == '0));

  for (genvar j = 0; j < NS; j++) begin : g_src
    logic [NM-1:0] col;
    always_comb for (int k = 0; k < NM; k++) col[k] = held_i[k*NS + j];

    p_drop_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ce_i || !USE_CE) && miss_i[j]) |-> s_ready_o[j]);

    p_one_owner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col) <= 1);
  end

  for (genvar k = 0; k < NM; k++) begin : g_snk
    p_single_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(held_i[k*NS +: NS]));

    if (REL_ON_LAST) begin : g_last
      p_last_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_valid_o[k] && m_ready_i[k] && m_last_o[k]) |=> (held_i[k*NS +: NS] == '0));
    end
  end
endmodule

bind strm_xbar xbar_chk #(
  .NS(NS), .NM(NM), .REL_ON_LAST(REL_ON_LAST), .USE_CE(USE_CE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_i     (ce_i),
  .s_ready_o(s_ready_o),
  .miss_i   (miss),
  .m_valid_o(m_valid_o),
  .m_ready_i(m_ready_i),
  .m_last_o (m_last_o),
  .held_i   (held)
);

// File: tb/tb_strm_xbar.sv
`timescale 1ns/1ps
module tb_strm_xbar;
  localparam int NS = 3;
  localparam int NM = 2;
  localparam int DW = 8;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic ce = 1'b1;
  logic [NS-1:0]    s_valid = '0, s_last = '0;
  logic [NS*DW-1:0] s_data = '0;
  logic [NS*TW-1:0] s_dest = '0;
  logic [NM-1:0]    m_ready = '0;
  logic [NS-1:0]    s_ready, s_ready_f;
  logic [NM-1:0]    m_valid, m_last, m_valid_f, m_last_f;
  logic [NM*DW-1:0] m_data, m_data_f;
  logic [NM*TW-1:0] m_dest, m_dest_f;
  logic [NS-1:0]    acc = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strm_xbar #(.NS(NS), .NM(NM), .DATA_W(DW), .DEST_W(TW), .ARB_RR(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data), .s_last_i(s_last), .s_dest_i(s_dest),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data), .m_last_o(m_last), .m_dest_o(m_dest)
  );

  strm_xbar #(.NS(NS), .NM(NM), .DATA_W(DW), .DEST_W(TW), .ARB_RR(1'b0)) dut_fp (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce),
    .s_valid_i(s_valid), .s_ready_o(s_ready_f), .s_data_i(s_data), .s_last_i(s_last), .s_dest_i(s_dest),
    .m_valid_o(m_valid_f), .m_ready_i(m_ready), .m_data_o(m_data_f), .m_last_o(m_last_f), .m_dest_o(m_dest_f)
  );

  // sink index for a destination, -1 when no window matches
  function automatic int route(input int d);
    if (d >= 0 && d <= 2) return 0;
    if (d >= 2 && d <= 5) return 1;
    return -1;
  endfunction

  function automatic int md(input int k);
    return int'(m_data[k*DW +: DW]);
  endfunction

  function automatic int md_f(input int k);
    return int'(m_data_f[k*DW +: DW]);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic drv(input int j, input bit v, input int d, input int dat, input bit l);
    s_valid[j] = v;
    s_dest[j*TW +: TW] = TW'(d);
    s_data[j*DW +: DW] = DW'(dat);
    s_last[j] = l;
  endtask

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic smp;
    @(negedge clk);
  endtask

  task automatic do_reset;
    s_valid = '0;
    s_dest = '0;
    s_last = '0;
    m_ready = '0;
    ce = 1'b1;
    rst_ni = 1'b0;
    smp;
    chk("R12 valid", int'(m_valid), 0);
    chk("R12 ready", int'(s_ready), 0);
    cyc;
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #1;
    do_reset;
    smp;
    chk("R12 idle after reset", int'(m_valid), 0);
    cyc;

    // window decode and drop
    m_ready = '1;
    drv(0, 1, 2, 'hA1, 1); smp;
    chk("R1 overlap to sink0", int'(m_valid), 1);
    chk("R1 data", md(0), 'hA1);
    chk("R3 ready", int'(s_ready), 1);
    cyc;
    drv(0, 1, 4, 'hB2, 1); smp;
    chk("R1 sink1", int'(m_valid), 2);
    chk("R1 data1", md(1), 'hB2);
    chk("R1 dest1", int'(m_dest[TW +: TW]), 4);
    cyc;
    drv(0, 1, 5, 'hC3, 1); smp;
    chk("R1 high edge", int'(m_valid), 2);
    cyc;
    drv(0, 1, 0, 'hD4, 1); smp;
    chk("R1 low edge", int'(m_valid), 1);
    cyc;
    for (int d = 6; d <= 7; d++) begin
      drv(0, 1, d, 'hE5, 1); smp;
      chk("R2 no sink", int'(m_valid), 0);
      chk("R2 accepted", int'(s_ready[0]), 1);
      cyc;
    end

    // rotation vs priority with single-beat packets
    do_reset;
    m_ready = 2'b01;
    drv(0, 1, 1, 'h10, 1); drv(1, 1, 1, 'h11, 1); drv(2, 1, 1, 'h12, 1);
    for (int c = 0; c < 4; c++) begin
      smp;
      chk("R5/R9 rotation", md(0), 'h10 + (c % 3));
      chk("R3 ready owner", int'(s_ready), 1 << (c % 3));
      chk("R4 priority", md_f(0), 'h10);
      cyc;
    end

    // hold and beat limit
    do_reset;
    m_ready = 2'b00;
    drv(0, 1, 1, 'h20, 0); drv(1, 1, 1, 'h21, 0); smp;
    chk("R3 stalled valid", int'(m_valid[0]), 1);
    chk("R3 stalled data", md(0), 'h20);
    chk("R3 stalled ready", int'(s_ready), 0);
    cyc;
    m_ready = 2'b01;
    for (int c = 0; c < 6; c++) begin
      smp;
      chk("R7 beat limit", md(0), (c < 3) ? 'h20 : 'h21);
      chk("R6 hold", int'(s_ready), (c < 3) ? 1 : 2);
      chk("R4 reselect", md_f(0), 'h20);
      cyc;
    end

    // idle release
    do_reset;
    m_ready = 2'b01;
    drv(0, 1, 1, 'h30, 0); smp;
    chk("R8 first beat", md(0), 'h30);
    cyc;
    s_valid[0] = 1'b0;
    drv(1, 1, 1, 'h31, 0);
    for (int c = 0; c < 2; c++) begin
      smp;
      chk("R8 held idle", int'(m_valid), 0);
      chk("R8 waiter", int'(s_ready[1]), 0);
      cyc;
    end
    smp;
    chk("R8 released", int'(m_valid[0]), 1);
    chk("R8 new owner", md(0), 'h31);
    cyc;

    // concurrent grants and single ownership
    do_reset;
    m_ready = 2'b11;
    drv(0, 1, 1, 'h40, 0); drv(1, 1, 4, 'h41, 0); smp;
    chk("R10 both sinks", int'(m_valid), 3);
    chk("R10 data0", md(0), 'h40);
    chk("R10 data1", md(1), 'h41);
    chk("R10 ready", int'(s_ready), 3);
    cyc;
    drv(0, 1, 4, 'h42, 0); s_valid[1] = 1'b0;
    for (int c = 0; c < 2; c++) begin
      smp;
      chk("R10 blocked", int'(m_valid), 0);
      chk("R10 blocked ready", int'(s_ready[0]), 0);
      cyc;
    end
    smp;
    chk("R10 moved", int'(m_valid), 2);
    chk("R10 moved data", md(1), 'h42);
    chk("R10 moved ready", int'(s_ready[0]), 1);
    cyc;

    // clock enable freeze
    do_reset;
    m_ready = 2'b01;
    drv(0, 1, 1, 'h50, 0); drv(1, 1, 1, 'h51, 0); smp;
    chk("R11 before", md(0), 'h50);
    cyc;
    ce = 1'b0;
    for (int c = 0; c < 3; c++) begin
      smp;
      chk("R11 valid low", int'(m_valid), 0);
      chk("R11 ready low", int'(s_ready), 0);
      cyc;
    end
    ce = 1'b1;
    for (int c = 0; c < 3; c++) begin
      smp;
      chk("R11 count frozen", md(0), (c < 2) ? 'h50 : 'h51);
      cyc;
    end

    // random traffic against routing model
    do_reset;
    acc = '0;
    for (int n = 0; n < 3000; n++) begin
      for (int j = 0; j < NS; j++) begin
        if (!s_valid[j] || acc[j])
          drv(j, ($urandom % 4) != 0, $urandom % 8, $urandom % 256, ($urandom % 3) == 0);
      end
      m_ready = NM'($urandom);
      if ($urandom % 4 == 0) m_ready = '1;
      ce = ($urandom % 8) != 0;
      smp;
      begin
        int nm, ns;
        bit ok, bad_drop;
        nm = 0; ns = 0; ok = 1'b1; bad_drop = 1'b0;
        for (int k = 0; k < NM; k++) begin
          if (m_valid[k] && m_ready[k]) begin
            bit f;
            f = 1'b0;
            nm++;
            for (int j = 0; j < NS; j++)
              if (s_valid[j] && s_ready[j] && route(int'(s_dest[j*TW +: TW])) == k &&
                  s_data[j*DW +: DW] == m_data[k*DW +: DW] && s_dest[j*TW +: TW] == m_dest[k*TW +: TW])
                f = 1'b1;
            if (!f) ok = 1'b0;
          end
        end
        for (int j = 0; j < NS; j++) begin
          if (s_valid[j] && s_ready[j] && route(int'(s_dest[j*TW +: TW])) != -1) ns++;
          if (s_valid[j] && ce && route(int'(s_dest[j*TW +: TW])) == -1 && !s_ready[j]) bad_drop = 1'b1;
        end
        chk("R1 random routing", int'(ok && nm == ns), 1);
        chk("R2 random drop", int'(bad_drop), 0);
      end
      acc = s_valid & s_ready;
      cyc;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule